// File: doc/BRIEF.md
# Synchronous SRAM Sleep-Mode Power Controller

This block sits beside the control front-end of a synchronous SRAM and governs its low-power sleep mode. An asynchronous, active-high sleep request is resynchronised to the clock. Once the synchronised request is seen, the controller spends a fixed entry delay before it declares the interface asleep. While asleep it gates the clocked command inputs, forces the data drivers to high impedance and presents a deselect to the array. The array contents and all other stored state are never touched. Retention and the analog current reduction are represented only by the status flags.

When the request drops, the controller opens a recovery window counted in clock cycles. During that window reads and deselects pass to the array. Any write is replaced by a deselect and flagged with a single-cycle error pulse. Raising the request again inside the window sends the controller straight back to the entry delay. An undriven request line is expected to be tied low by the surrounding logic, so the block treats it as normal operation.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: Directly after reset the block reports ready=1, asleep=0, out_hiz=0, in_gate=0 and wr_err=0.
- R2: If sleep_req is high before a clock edge, asleep rises exactly SYNC_STAGES+ENTRY_CYC+1 edges later. That is two synchroniser edges, one detection edge and ENTRY_CYC entry cycles, or 5 edges with the default values.
- R3: While asleep=1, in_gate=1 and out_hiz=1, and cmd_o is deselect (2'b00) for every cmd_i value.
- R4: After sleep_req falls, asleep drops on edge SYNC_STAGES+1 and the block enters recovery. In recovery in_gate=0, out_hiz=0 and ready=0. ready returns RECOVER_CYC edges later.
- R5: During recovery a write (2'b10) on cmd_i leaves cmd_o as deselect (2'b00), and wr_err is 1 in that same cycle. Deselect (2'b00) and read (2'b01) pass through unchanged with wr_err=0.
- R6: When not asleep and not recovering, which includes the entry delay, cmd_o equals cmd_i for deselect, read and write, and wr_err=0.
- R7: The reserved command code 2'b11 always leaves the block as deselect (2'b00) and never raises wr_err.
- R8: If sleep_req is raised while recovery is still running, the controller returns to the entry delay. ready goes back to 1 on detection, and asleep rises ENTRY_CYC edges after detection.
- R9: A sleep_req pulse lasting one clock cycle still commits the block to a full entry and one sleep cycle. The block then goes into a complete recovery window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| cmd_i | input | 2 | Decoded command: 00 deselect, 01 read, 10 write, 11 reserved |
| cmd_o | output | 2 | Filtered command for the array, same encoding |
| in_gate | output | 1 | High while clocked inputs are gated off |
| out_hiz | output | 1 | High while data drivers must be high impedance |
| asleep | output | 1 | Sleep status flag |
| ready | output | 1 | High when unrestricted operation is allowed |
| wr_err | output | 1 | High in a recovery cycle where a write was dropped |

## Verification
The bench builds the block with SYNC_STAGES=2, ENTRY_CYC=2 and RECOVER_CYC=5. That window is long enough for a request raised in the middle of recovery to be detected while recovery is still under way, which is needed to exercise the return to entry in R8. In each of the four states (normal, entry, sleep and every recovery cycle) the bench applies all four command codes. It also checks the status outputs on every edge of each entry and wake-up sequence against latencies computed from the three parameters.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    SLP_ACTIVE  = 2'd0,
    SLP_ENTER   = 2'd1,
    SLP_SLEEP   = 2'd2,
    SLP_RECOVER = 2'd3
  } slp_state_t;

  localparam logic [1:0] CMD_DESEL = 2'b00;
  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_WRITE = 2'b10;
  localparam logic [1:0] CMD_RSVD  = 2'b11;
endpackage

// File: rtl/slp_zz_sync.sv
module slp_zz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], async_i};
  end

  assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int ENTRY_CYC   = 2,
  parameter int RECOVER_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zz_i,
  output slp_state_t state_o
);
  localparam int MAXC = (ENTRY_CYC > RECOVER_CYC) ? ENTRY_CYC : RECOVER_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ELOAD = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] RLOAD = CW'(RECOVER_CYC - 1);

  slp_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SLP_ACTIVE: begin
        if (zz_i) begin
          state_d = SLP_ENTER;
          cnt_d   = ELOAD;
        end
      end
      SLP_ENTER: begin
        if (cnt_q == '0) state_d = SLP_SLEEP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      SLP_SLEEP: begin
        if (!zz_i) begin
          state_d = SLP_RECOVER;
          cnt_d   = RLOAD;
        end
      end
      SLP_RECOVER: begin
        if (zz_i) begin
          state_d = SLP_ENTER;
          cnt_d   = ELOAD;
        end else if (cnt_q == '0) begin
          state_d = SLP_ACTIVE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = SLP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLP_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R2
  sleep_from_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLP_SLEEP && $past(state_q) != SLP_SLEEP) |-> $past(state_q) == SLP_ENTER);
  // R2
  enter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLP_ENTER) |-> (cnt_q < CW'(ENTRY_CYC)));
  // R4
  recover_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLP_ACTIVE && $past(state_q) == SLP_RECOVER) |-> ($past(cnt_q) == '0 && !$past(zz_i)));
  // R8
  reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLP_RECOVER && zz_i) |=> state_q == SLP_ENTER);
endmodule

// File: rtl/slp_cmd_gate.sv
module slp_cmd_gate
  import slp_pkg::*;
(
  input  slp_state_t state_i,
  input  logic [1:0] cmd_i,
  output logic [1:0] cmd_o,
  output logic       wr_err_o,
  output logic       in_gate_o,
  output logic       out_hiz_o
);
  logic sleeping, recovering;

  assign sleeping   = (state_i == SLP_SLEEP);
  assign recovering = (state_i == SLP_RECOVER);

  always_comb begin
    cmd_o    = cmd_i;
    wr_err_o = 1'b0;
    if (sleeping || cmd_i == CMD_RSVD) begin
      cmd_o = CMD_DESEL;
    end else if (recovering && cmd_i == CMD_WRITE) begin
      cmd_o    = CMD_DESEL;
      wr_err_o = 1'b1;
    end
  end

  assign in_gate_o = sleeping;
  assign out_hiz_o = sleeping;
endmodule

// File: rtl/slp_pwr_ctrl.sv
module slp_pwr_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int RECOVER_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] cmd_i,
  output logic [1:0] cmd_o,
  output logic       in_gate,
  output logic       out_hiz,
  output logic       asleep,
  output logic       ready,
  output logic       wr_err
);
  logic       zz_s;
  slp_state_t state;

  slp_zz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sleep_req),
    .sync_o  (zz_s)
  );

  slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOVER_CYC(RECOVER_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .zz_i    (zz_s),
    .state_o (state)
  );

  slp_cmd_gate u_gate (
    .state_i   (state),
    .cmd_i     (cmd_i),
    .cmd_o     (cmd_o),
    .wr_err_o  (wr_err),
    .in_gate_o (in_gate),
    .out_hiz_o (out_hiz)
  );

  assign asleep = (state == SLP_SLEEP);
  assign ready  = (state == SLP_ACTIVE) || (state == SLP_ENTER);

  // R3
  asleep_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (out_hiz && in_gate && cmd_o == CMD_DESEL));
  // R5
  rec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !asleep) |-> (cmd_o != CMD_WRITE));
  // R5
  err_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (cmd_i == CMD_WRITE && !ready && !asleep));
  // R7
  rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_RSVD) |-> (cmd_o == CMD_DESEL && !wr_err));
endmodule

// File: tb/slp_pwr_ctrl_bench.sv
module slp_pwr_ctrl_bench;
  localparam int SYNC  = 2;
  localparam int ENTRY = 2;
  localparam int REC   = 5;
  localparam int SLEEP_LAT = SYNC + ENTRY + 1;
  localparam int WAKE_LAT  = SYNC + 1;
  localparam int WDOG      = 20000;

  logic clk, rst_n, sleep_req;
  logic [1:0] cmd_i, cmd_o;
  logic in_gate, out_hiz, asleep, ready, wr_err;
  int checks = 0, failures = 0, cyc = 0;

  slp_pwr_ctrl #(.SYNC_STAGES(SYNC), .ENTRY_CYC(ENTRY), .RECOVER_CYC(REC)) u_slp_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmd_i(cmd_i), .cmd_o(cmd_o),
    .in_gate(in_gate), .out_hiz(out_hiz), .asleep(asleep), .ready(ready), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // mode 0 = normal/entry, 1 = asleep, 2 = recovery
  function automatic int exp_cmd(input int mode, input int c);
    if (c == 3 || mode == 1) return 0;
    if (mode == 2 && c == 2) return 0;
    return c;
  endfunction

  task automatic sweep(input int mode, input string req);
    for (int c = 0; c < 4; c++) begin
      cmd_i = 2'(c);
      #1;
      chk(c == 3 ? "R7" : req, int'(cmd_o), exp_cmd(mode, c));
      chk(c == 3 ? "R7" : req, int'(wr_err), (mode == 2 && c == 2) ? 1 : 0);
    end
    cmd_i = 2'b00;
  endtask

  task automatic enter_sleep();
    sleep_req = 1'b1;
    for (int k = 1; k <= SLEEP_LAT; k++) begin
      step();
      chk("R2", int'(asleep), (k >= SLEEP_LAT) ? 1 : 0);
      chk("R2", int'(ready), (k >= SLEEP_LAT) ? 0 : 1);
      if (k == SYNC + 1) sweep(0, "R6");
    end
  endtask

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; cmd_i = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", int'(ready), 1);
    chk("R1", int'(asleep), 0);
    chk("R1", int'(out_hiz), 0);
    chk("R1", int'(in_gate), 0);
    chk("R1", int'(wr_err), 0);
    step();
    sweep(0, "R6");

    // R2 entry latency, R3 isolation
    enter_sleep();
    for (int k = 0; k < 3; k++) begin
      chk("R3", int'(out_hiz), 1);
      chk("R3", int'(in_gate), 1);
      sweep(1, "R3");
      step();
      chk("R3", int'(asleep), 1);
    end

    // R4 wake-up and recovery window, R5 write filtering
    sleep_req = 1'b0;
    for (int k = 1; k <= WAKE_LAT + REC; k++) begin
      step();
      chk("R4", int'(asleep), (k < WAKE_LAT) ? 1 : 0);
      chk("R4", int'(ready), (k >= WAKE_LAT + REC) ? 1 : 0);
      if (k >= WAKE_LAT && k < WAKE_LAT + REC) begin
        chk("R4", int'(out_hiz), 0);
        chk("R4", int'(in_gate), 0);
        sweep(2, "R5");
      end
    end
    sweep(0, "R6");

    // R8 reassertion during recovery
    enter_sleep();
    sleep_req = 1'b0;
    repeat (WAKE_LAT) step();
    chk("R8", int'(ready), 0);
    sleep_req = 1'b1;
    for (int k = 1; k <= WAKE_LAT + ENTRY; k++) begin
      step();
      chk("R8", int'(asleep), (k == WAKE_LAT + ENTRY) ? 1 : 0);
      chk("R8", int'(ready), (k >= WAKE_LAT && k < WAKE_LAT + ENTRY) ? 1 : 0);
    end
    sleep_req = 1'b0;
    repeat (WAKE_LAT + REC + 2) step();
    chk("R8", int'(ready), 1);

    // R9 single-cycle request
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    for (int k = 2; k <= SLEEP_LAT + 1 + REC; k++) begin
      step();
      chk("R9", int'(asleep), (k == SLEEP_LAT) ? 1 : 0);
      chk("R9", int'(ready), (k < SLEEP_LAT || k >= SLEEP_LAT + 1 + REC) ? 1 : 0);
    end
    sweep(0, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule